// File: doc/BRIEF.md
# Byte-Wide Ethernet Frame Check Engine

This block computes the 32-bit Ethernet frame check sequence at one byte per clock. It serves both directions of a MAC datapath. Bytes arrive on an 8-bit bus with a valid qualifier and with strobes that mark the first and last byte of a frame. Each byte holds the first bit received from the line in its least significant position. The engine reverses each byte before it enters an MSB-first parallel update of the 0x04C11DB7 polynomial. The running register is preset to all ones by the start strobe in the same cycle that the first byte is absorbed.

In receive mode the caller feeds the payload followed by the four appended check bytes. After the last byte the engine compares the register against the fixed good-frame residue and reports the verdict one cycle later. In transmit mode the caller feeds only the payload. On the cycle after the last byte the engine starts to emit four check bytes. Each byte is the complement of the final register, taken from the most significant byte downward and bit-reversed into line order.

Top module: `fcs_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `frame_done`, `frame_good`, `tx_valid` and `tx_last` are low.
- R2: A byte with `in_valid` and `in_sof` high starts a new check from an all-ones register, discarding any earlier partial frame, so back-to-back frames and restarted frames are independent.
- R3: The check uses the 0x04C11DB7 polynomial with each byte entered least significant bit first. For the ASCII payload "123456789" in transmit mode the emitted bytes are 0x26, 0x39, 0xF4, 0xCB in that order.
- R4: Cycles with `in_valid` low leave the running check unchanged, so idle gaps inside a frame do not alter either verdict or emitted bytes.
- R5: In receive mode (`mode_tx`=0), the cycle after a byte with `in_valid` and `in_eof` high has `frame_done` high for exactly that cycle. `frame_good` is high only then, and only when the register holds 0xC704DD7B after that byte, which is the case when the appended check bytes are correct.
- R6: A receive frame with any payload or check byte altered gives `frame_done` high with `frame_good` low.
- R7: A receive frame of fewer than 4 bytes, including a single byte carrying both strobes, gives `frame_good` low.
- R8: In transmit mode (`mode_tx`=1), the four cycles that follow the last payload byte carry `tx_valid` high with the check bytes in order, and `tx_last` is high on the fourth of them only. `frame_done` stays low for transmit frames.
- R9: Check bytes emitted in transmit mode and appended to the same payload form a frame that receive mode marks good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_tx | input | 1 | 0 selects receive checking, 1 selects transmit generation |
| in_valid | input | 1 | Byte on `in_data` is absorbed this cycle |
| in_sof | input | 1 | Qualified byte is the first of a frame |
| in_eof | input | 1 | Qualified byte is the last of a frame |
| in_data | input | 8 | Data byte, first line bit in bit 0 |
| frame_done | output | 1 | One-cycle pulse after a receive frame ends |
| frame_good | output | 1 | Receive verdict, meaningful while `frame_done` is high |
| tx_valid | output | 1 | `tx_data` holds a check byte to append |
| tx_data | output | 8 | Check byte in line order, first line bit in bit 0 |
| tx_last | output | 1 | Marks the fourth check byte |

## Verification
The assertions rely on the caller's framing discipline. A new transmit frame does not end while the previous four check bytes are still being emitted. `in_sof` and `in_eof` are ignored unless `in_valid` is high. The stimulus follows both rules. It drives whole frames through one task and keeps at least four idle cycles after every transmit frame. Gaps with `in_valid` low, restarts by a second start strobe, and single-byte frames all stay within these rules. A behavioural model in the bench uses the reflected byte-serial form of the check. It predicts every output on every cycle.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    parameter int DATA_W = 8;
    parameter int CRC_W  = 32;

    localparam logic [CRC_W-1:0] POLY    = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] PRESET  = '1;
    localparam logic [CRC_W-1:0] RESIDUE = 32'hC704_DD7B;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CRC_W-1:0]  crc_t;

    typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;

    typedef struct packed {
        logic  valid;
        logic  sof;
        logic  eof;
        dir_e  dir;
        byte_t data;
    } beat_t;

    function automatic byte_t rev_byte(input byte_t b);
        byte_t r;
        for (int i = 0; i < DATA_W; i++) r[i] = b[DATA_W-1-i];
        return r;
    endfunction

    // MSB-first parallel update over one reversed byte
    function automatic crc_t crc_step(input crc_t c_in, input byte_t b);
        crc_t  c;
        byte_t d;
        logic  fb;
        c = c_in;
        d = rev_byte(b);
        for (int i = DATA_W-1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/fcs_core.sv
module fcs_core
    import fcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat,
    output crc_t  crc_next,
    output crc_t  crc_q
);
    crc_t base;

    always_comb begin
        base     = beat.sof ? PRESET : crc_q;
        crc_next = crc_step(base, beat.data);
    end

    always_ff @(posedge clk) begin
        if (rst)             crc_q <= PRESET;
        else if (beat.valid) crc_q <= crc_next;
    end

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !beat.valid |=> $stable(crc_q));

endmodule

// File: rtl/fcs_rx_check.sv
module fcs_rx_check
    import fcs_pkg::*;
#(
    parameter int MIN_LEN = 4,
    parameter int CNT_W   = $clog2(MIN_LEN + 1)
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat,
    input  crc_t  crc_next,
    output logic  frame_done,
    output logic  frame_good
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_LEN);

    logic [CNT_W-1:0] len_q, len_nxt;
    logic             ends_here;

    always_comb begin
        if (beat.sof)            len_nxt = CNT_W'(1);
        else if (len_q == CNT_MAX) len_nxt = CNT_MAX;
        else                     len_nxt = len_q + CNT_W'(1);
        ends_here = beat.valid && beat.eof && (beat.dir == DIR_RX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q      <= '0;
            frame_done <= 1'b0;
            frame_good <= 1'b0;
        end else begin
            if (beat.valid) len_q <= len_nxt;
            frame_done <= ends_here;
            frame_good <= ends_here && (crc_next == RESIDUE) && (len_nxt >= CNT_MIN);
        end
    end

    assert_done_follows_eof_R5: assert property (@(posedge clk) disable iff (rst)
        ends_here |=> frame_done);
    assert_good_inside_done_R5: assert property (@(posedge clk) disable iff (rst)
        frame_good |-> frame_done);
    assert_single_byte_bad_R7: assert property (@(posedge clk) disable iff (rst)
        beat.valid && beat.sof && beat.eof |=> !frame_good);

endmodule

// File: rtl/fcs_tx_emit.sv
module fcs_tx_emit
    import fcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat,
    input  crc_t  crc_next,
    output logic  tx_valid,
    output byte_t tx_data,
    output logic  tx_last
);
    localparam int NBYTES = CRC_W / DATA_W;
    localparam int IDX_W  = $clog2(NBYTES);

    crc_t             shift_q;
    logic [IDX_W-1:0] idx_q;
    logic             launch;

    assign launch = beat.valid && beat.eof && (beat.dir == DIR_TX);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            shift_q  <= '0;
            idx_q    <= '0;
        end else if (launch) begin
            tx_valid <= 1'b1;
            shift_q  <= ~crc_next;
            idx_q    <= '0;
        end else if (tx_valid) begin
            shift_q  <= {shift_q[CRC_W-DATA_W-1:0], {DATA_W{1'b0}}};
            idx_q    <= idx_q + IDX_W'(1);
            tx_valid <= (idx_q != IDX_W'(NBYTES-1));
        end
    end

    always_comb begin
        tx_data = tx_valid ? rev_byte(shift_q[CRC_W-1 -: DATA_W]) : '0;
        tx_last = tx_valid && (idx_q == IDX_W'(NBYTES-1));
    end

    assert_last_in_burst_R8: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);
    assert_burst_unbroken_R8: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_last |=> tx_valid);
    assert_burst_starts_R8: assert property (@(posedge clk) disable iff (rst)
        launch |=> tx_valid && !tx_last);
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_last |-> !launch);

endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
    import fcs_pkg::*;
#(
    parameter int MIN_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_tx,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic [7:0] in_data,
    output logic       frame_done,
    output logic       frame_good,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last
);
    beat_t beat;
    crc_t  crc_next;
    crc_t  crc_q;

    always_comb begin
        beat.valid = in_valid;
        beat.sof   = in_valid && in_sof;
        beat.eof   = in_valid && in_eof;
        beat.dir   = mode_tx ? DIR_TX : DIR_RX;
        beat.data  = in_data;
    end

    fcs_core u_core (
        .clk      (clk),
        .rst      (rst),
        .beat     (beat),
        .crc_next (crc_next),
        .crc_q    (crc_q)
    );

    fcs_rx_check #(.MIN_LEN(MIN_LEN)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .beat       (beat),
        .crc_next   (crc_next),
        .frame_done (frame_done),
        .frame_good (frame_good)
    );

    fcs_tx_emit u_tx (
        .clk      (clk),
        .rst      (rst),
        .beat     (beat),
        .crc_next (crc_next),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last)
    );

    assert_rx_no_tx_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_eof && mode_tx |=> !frame_done);

endmodule

// File: tb/sim_fcs_engine.sv
`timescale 1ns/1ps
module sim_fcs_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_tx = 1'b0, in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       frame_done, frame_good, tx_valid, tx_last;
    logic [7:0] tx_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    fcs_engine u0 (
        .clk(clk), .rst(rst), .mode_tx(mode_tx), .in_valid(in_valid),
        .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .frame_done(frame_done), .frame_good(frame_good),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
    );

    // ---------------- behavioural reference (reflected, bit-serial) ----------
    function automatic logic [31:0] ref_reg(input logic [7:0] q[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (q[k]) begin
            c ^= {24'h0, q[k]};
            for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return c;
    endfunction

    logic [7:0] frame_q[$];
    logic [7:0] txexp_q[$];
    logic [7:0] cap_q[$];
    logic       e_done = 0, e_good = 0, e_txv = 0, e_last = 0;
    logic [7:0] e_txd = 0;
    logic       seen_done = 0, seen_good = 0;

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (rst) begin
            frame_q.delete(); txexp_q.delete();
            e_done = 0; e_good = 0; e_txv = 0; e_last = 0; e_txd = 0;
        end else begin
            logic [31:0] f;
            e_done = 0; e_good = 0;
            if (in_valid) begin
                if (in_sof) frame_q.delete();
                frame_q.push_back(in_data);
                if (in_eof && !mode_tx) begin
                    e_done = 1;
                    e_good = (frame_q.size() >= 4) && (ref_reg(frame_q) == 32'hDEBB_20E3);
                end
                if (in_eof && mode_tx) begin
                    f = ~ref_reg(frame_q);
                    for (int k = 0; k < 4; k++) txexp_q.push_back(f[8*k +: 8]);
                end
            end
            e_txv = 0; e_last = 0; e_txd = 0;
            if (txexp_q.size() > 0) begin
                e_txv = 1;
                e_txd = txexp_q.pop_front();
                e_last = (txexp_q.size() == 0);
            end
        end
        cmp("R5 frame_done", {7'd0, frame_done}, {7'd0, e_done});
        cmp("R5/R6/R7 frame_good", {7'd0, frame_good}, {7'd0, e_good});
        cmp("R8 tx_valid", {7'd0, tx_valid}, {7'd0, e_txv});
        cmp("R8 tx_last", {7'd0, tx_last}, {7'd0, e_last});
        cmp("R3/R8 tx_data", tx_data, e_txd);
        if (tx_valid) cap_q.push_back(tx_data);
        if (frame_done) begin seen_done = 1; seen_good = frame_good; end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic tx, input logic [7:0] q[$], input int gap_every);
        foreach (q[k]) begin
            @(negedge clk);
            mode_tx = tx; in_valid = 1; in_data = q[k];
            in_sof = (k == 0); in_eof = (k == q.size() - 1);
            if (gap_every > 0 && (k % gap_every) == gap_every - 1 && k != q.size() - 1) begin
                @(negedge clk);
                in_valid = 0; in_sof = 1; in_eof = 1; in_data = 8'hA5;
            end
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0; in_data = 8'h00;
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_rx(input string tag, input logic good);
        checks++;
        if (!(seen_done && seen_good == good)) begin
            errors++;
            $display("FAIL %s: actual done=%0b good=%0b expected done=1 good=%0b",
                     tag, seen_done, seen_good, good);
        end
        seen_done = 0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] vec[$];
        logic [7:0] pl[$];
        logic [7:0] fr[$];
        vec = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        repeat (3) @(negedge clk);
        // R1: reset state checked by the per-cycle model while rst is high
        rst = 0;
        @(negedge clk);
        cmp("R1 outputs after reset", {4'd0, frame_done, frame_good, tx_valid, tx_last}, 8'h00);

        // R3 / R8: known vector in transmit mode
        cap_q.delete();
        send(1, vec, 0);
        cmp("R3 fcs byte count", 8'(cap_q.size()), 8'd4);
        if (cap_q.size() == 4) begin
            cmp("R3 fcs byte 0", cap_q[0], 8'h26);
            cmp("R3 fcs byte 1", cap_q[1], 8'h39);
            cmp("R3 fcs byte 2", cap_q[2], 8'hF4);
            cmp("R3 fcs byte 3", cap_q[3], 8'hCB);
        end

        // R5: known frame with its check appended
        fr = vec; fr.push_back(8'h26); fr.push_back(8'h39); fr.push_back(8'hF4); fr.push_back(8'hCB);
        send(0, fr, 0);
        expect_rx("R5 known good frame", 1);

        // R4: same frame with idle gaps
        send(0, fr, 2);
        expect_rx("R4 gaps ignored", 1);

        // R6: corrupted payload and corrupted check byte
        fr[3] = fr[3] ^ 8'h10;
        send(0, fr, 0);
        expect_rx("R6 corrupted payload", 0);
        fr[3] = fr[3] ^ 8'h10; fr[12] = 8'hCA;
        send(0, fr, 0);
        expect_rx("R6 corrupted fcs", 0);
        fr[12] = 8'hCB;

        // R7: short frames
        send(0, '{8'h5A}, 0);
        expect_rx("R7 single byte", 0);
        send(0, '{8'h00, 8'h11, 8'h22}, 0);
        expect_rx("R7 three bytes", 0);

        // R2: restart mid-frame, then back-to-back good frames
        @(negedge clk);
        mode_tx = 0; in_valid = 1; in_sof = 1; in_eof = 0; in_data = 8'hEE;
        @(negedge clk); in_sof = 0; in_data = 8'h77;
        send(0, fr, 0);
        expect_rx("R2 restart by sof", 1);
        send(0, fr, 0);
        expect_rx("R2 back-to-back", 1);

        // R9: loopback of generated check bytes, several payloads
        for (int n = 1; n <= 24; n += 5) begin
            pl.delete();
            for (int k = 0; k < n; k++) pl.push_back(8'((k * 37 + n * 11) ^ 8'h5C));
            cap_q.delete();
            send(1, pl, (n % 3) + 1);
            fr = pl;
            foreach (cap_q[k]) fr.push_back(cap_q[k]);
            send(0, fr, 0);
            expect_rx("R9 loopback residue", 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule